// File: doc/BRIEF.md
# Two-Plane Hardware Cursor Overlay

This block keeps a 64 by 64 cursor image at two bits per pixel and lays it over a live pixel stream. The host first streams the image in through a byte port whose address steps forward by itself. Plane 0 fills the lower half of that address space and plane 1 fills the upper half. The host then writes the cursor colours through a second byte port, one component at a time. Video timing and palette lookup sit outside the block. The block receives the current pixel's screen column and line with its RGB value. Exactly one clock later it returns either that pixel unchanged or one of the two cursor colours.

The cursor position registers hold the screen coordinate plus 64. The cursor can therefore hang partly over the left or top edge of the screen. With interlace selected, bit 0 of the vertical position takes no part in the comparison. The colour file also holds an overscan entry at address 0. The cursor never uses that entry, and its value is brought out on its own port.

Top module: `cursor_overlay`

## Requirements
- R1: After a clock edge with `rst_n` low, `pix_out` is 0, every colour entry (and so `ovs_rgb`) is 0, the image write address is 0, and the colour port points at address 0, component 0.
- R2: `img_ld` sets the image write address (a write in the same cycle is dropped). Each `img_we` stores `img_wdata` at the current address and then adds one, wrapping from 1023 to 0. Addresses 0 to 511 form plane 0 and 512 to 1023 form plane 1.
- R3: Cursor pixel (c, r) reads bit 7 − (c mod 8) of byte r·8 + c/8 in each plane, so the most significant bit of a byte is its leftmost pixel.
- R4: Cursor pixel (c, r) covers screen pixel (pos_x − 64 + c, pos_y − 64 + r). Screen pixels outside the 64 by 64 window pass through unchanged, including when the window lies partly off the left or top edge.
- R5: When the cursor is enabled and covers a pixel: a plane 1 bit of 0 passes the input pixel through. A plane 1 bit of 1 selects the foreground colour if the plane 0 bit is 1, and the background colour if it is 0.
- R6: `col_ld` sets the colour address and clears the component index. Each `col_we` writes red, then green, then blue of the current address, and the address advances by one after the blue write, wrapping from 3 to 0. Address 1 is background, 2 is foreground and 0 is overscan (on `ovs_rgb`). Writes to address 3 are discarded.
- R7: With `mode` equal to 0 the cursor is never shown. Any nonzero `mode` enables the decode of R5.
- R8: With `interlace` high, the vertical window is computed as if bit 0 of `pos_y` were 0.
- R9: `pix_out` equals the decided value for the `pix_in`, `pix_x` and `pix_y` presented one clock earlier, whether or not the cursor covers the pixel.
- R10: Colours and pixels are packed with red in bits 23:16, green in 15:8 and blue in 7:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| img_ld | input | 1 | Load the image write address |
| img_ld_addr | input | 10 | Value for the image write address |
| img_we | input | 1 | Write one image byte and step the address |
| img_wdata | input | 8 | Image byte |
| col_ld | input | 1 | Load the colour address, clear component index |
| col_ld_addr | input | 2 | Value for the colour address |
| col_we | input | 1 | Write one colour component |
| col_wdata | input | 8 | Colour component |
| pos_we | input | 1 | Capture both position registers |
| pos_x_in | input | 12 | Horizontal position plus 64 |
| pos_y_in | input | 12 | Vertical position plus 64 |
| mode | input | 2 | Cursor mode, 0 disables |
| interlace | input | 1 | Ignore bit 0 of the vertical position |
| pix_x | input | 12 | Column of the incoming pixel |
| pix_y | input | 12 | Line of the incoming pixel |
| pix_in | input | 24 | Incoming pixel RGB |
| pix_out | output | 24 | Merged pixel, one clock later |
| ovs_rgb | output | 24 | Overscan colour entry |

## Verification
The bench sweeps every pixel of an 80 by 80 screen corner for several cursor placements. One placement leaves the window cut off at both the left and top edges. A wrong sign or a missing 64 offset there would shift the image, or wrap it into the far side of the screen. A reversed bit order within each byte would mirror every 8-pixel group, and a swapped plane role would paint transparent pixels. Two further sweeps use an odd vertical position, with and without interlace, which exposes a design that keeps bit 0 in interlace mode. The image load runs past address 1023 to prove the wrap. The colour load walks through the discarded address 3 into the overscan entry, which catches an address counter that steps on the wrong component or lets address 3 land on a live colour.

// File: rtl/cursor_pkg.sv
// Package: shared constants and the packed colour type of the cursor overlay.
// Assumes 8-bit colour components and a four-entry colour file.
package cursor_pkg;
    localparam int COMP_W  = 8;
    localparam int RGB_W   = 3 * COMP_W;
    localparam int N_COLOR = 4;

    typedef struct packed {
        logic [COMP_W-1:0] r;
        logic [COMP_W-1:0] g;
        logic [COMP_W-1:0] b;
    } rgb_t;

    localparam logic [1:0] COL_OVS = 2'd0;
    localparam logic [1:0] COL_BG  = 2'd1;
    localparam logic [1:0] COL_FG  = 2'd2;
    localparam logic [1:0] COL_NUL = 2'd3;
endpackage

// File: rtl/cursor_img_ram.sv
// Module: two-plane cursor image store with an auto-incrementing byte write port.
// The lower half of the address space is plane 0 and the upper half is plane 1.
// One combinational read returns the same byte offset from both planes.
// Assumes AW bits address both planes together.
module cursor_img_ram #(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld,
    input  logic [AW-1:0] ld_addr,
    input  logic          we,
    input  logic [7:0]    wdata,
    input  logic [AW-2:0] rd_addr,
    output logic [7:0]    p0_byte,
    output logic [7:0]    p1_byte
);
    localparam int DEPTH = 1 << AW;

    logic [7:0]    mem [DEPTH];
    logic [AW-1:0] wr_addr;

    // Write address: load, or step after each accepted byte.
    always_ff @(posedge clk) begin
        if (!rst_n)      wr_addr <= '0;
        else if (ld)     wr_addr <= ld_addr;
        else if (we)     wr_addr <= wr_addr + 1'b1;
    end

    // Byte storage; a load cycle drops any write.
    always_ff @(posedge clk) begin
        if (rst_n && we && !ld) mem[wr_addr] <= wdata;
    end

    // Read the same offset from both planes.
    always_comb begin
        p0_byte = mem[{1'b0, rd_addr}];
        p1_byte = mem[{1'b1, rd_addr}];
    end

    // R2: the write address wraps from the top back to zero.
    a_r2_addr_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !ld && wr_addr == '1) |=> (wr_addr == '0));
endmodule

// File: rtl/cursor_color_regs.sv
// Module: cursor colour file written one component at a time.
// Entry 0 is overscan, 1 background, 2 foreground; entry 3 discards writes.
// The address advances after each third component.
module cursor_color_regs
    import cursor_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ld,
    input  logic [1:0]  ld_addr,
    input  logic        we,
    input  logic [7:0]  wdata,
    output rgb_t        ovs,
    output rgb_t        bg,
    output rgb_t        fg
);
    logic [COMP_W-1:0] ent [N_COLOR][3];
    logic [1:0]        addr;
    logic [1:0]        comp;

    // Address and component index stepping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr <= COL_OVS;
            comp <= 2'd0;
        end else if (ld) begin
            addr <= ld_addr;
            comp <= 2'd0;
        end else if (we) begin
            if (comp == 2'd2) begin
                comp <= 2'd0;
                addr <= addr + 2'd1;
            end else begin
                comp <= comp + 2'd1;
            end
        end
    end

    // Component storage; entry 3 holds nothing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int e = 0; e < N_COLOR; e++)
                for (int c = 0; c < 3; c++)
                    ent[e][c] <= '0;
        end else if (we && !ld && addr != COL_NUL) begin
            ent[addr][comp] <= wdata;
        end
    end

    // Pack entries as red, green, blue.
    always_comb begin
        ovs = '{r: ent[0][0], g: ent[0][1], b: ent[0][2]};
        bg  = '{r: ent[1][0], g: ent[1][1], b: ent[1][2]};
        fg  = '{r: ent[2][0], g: ent[2][1], b: ent[2][2]};
    end

    // R6: the component index never reaches 3.
    a_r6_comp_range: assert property (@(posedge clk) disable iff (!rst_n)
        comp != 2'd3);
    // R6: a blue write moves to the next address.
    a_r6_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !ld && comp == 2'd2) |=> (addr == $past(addr) + 2'd1 && comp == 2'd0));
endmodule

// File: rtl/cursor_hit_calc.sv
// Module: maps a screen pixel to a cursor pixel.
// The position inputs carry a +DIM offset, so screen x maps to cursor
// column x + DIM - pos_x. Out-of-window results, negative ones included,
// show up as values of DIM or more after unsigned wrap.
// Assumes DIM is a power of two, at least 8.
module cursor_hit_calc #(
    parameter int POS_W = 12,
    parameter int DIM   = 64
) (
    input  logic [POS_W-1:0]         pix_x,
    input  logic [POS_W-1:0]         pix_y,
    input  logic [POS_W-1:0]         pos_x,
    input  logic [POS_W-1:0]         pos_y,
    input  logic                     interlace,
    output logic                     hit,
    output logic [2*$clog2(DIM)-4:0] byte_off,
    output logic [2:0]               bit_col
);
    localparam int LG = $clog2(DIM);
    localparam int DW = POS_W + 1;

    logic [POS_W-1:0] eff_y;
    logic [DW-1:0]    dx;
    logic [DW-1:0]    dy;

    // Window offsets; interlace drops bit 0 of the vertical position.
    always_comb begin
        eff_y    = interlace ? {pos_y[POS_W-1:1], 1'b0} : pos_y;
        dx       = {1'b0, pix_x} + DW'(DIM) - {1'b0, pos_x};
        dy       = {1'b0, pix_y} + DW'(DIM) - {1'b0, eff_y};
        hit      = (dx < DW'(DIM)) && (dy < DW'(DIM));
        byte_off = {dy[LG-1:0], dx[LG-1:3]};
        bit_col  = dx[2:0];
    end
endmodule

// File: rtl/cursor_overlay.sv
// Module: top of the two-plane cursor overlay.
// It stores the image and colours and registers the position. Each incoming
// pixel is merged with the cursor, with exactly one cycle of latency.
// Assumes the pixel counters come from external video timing.
module cursor_overlay
    import cursor_pkg::*;
#(
    parameter int POS_W  = 12,
    parameter int DIM    = 64,
    parameter int IMG_AW = $clog2(2 * DIM * DIM / 8)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              img_ld,
    input  logic [IMG_AW-1:0] img_ld_addr,
    input  logic              img_we,
    input  logic [7:0]        img_wdata,
    input  logic              col_ld,
    input  logic [1:0]        col_ld_addr,
    input  logic              col_we,
    input  logic [7:0]        col_wdata,
    input  logic              pos_we,
    input  logic [POS_W-1:0]  pos_x_in,
    input  logic [POS_W-1:0]  pos_y_in,
    input  logic [1:0]        mode,
    input  logic              interlace,
    input  logic [POS_W-1:0]  pix_x,
    input  logic [POS_W-1:0]  pix_y,
    input  logic [23:0]       pix_in,
    output logic [23:0]       pix_out,
    output logic [23:0]       ovs_rgb
);
    logic [POS_W-1:0]  pos_x, pos_y;
    logic              hit;
    logic [IMG_AW-2:0] byte_off;
    logic [2:0]        bit_col;
    logic [7:0]        p0_byte, p1_byte;
    logic              p0_bit, p1_bit;
    rgb_t              ovs_c, bg_c, fg_c;
    logic [23:0]       merged;

    // Position registers, captured together.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_x <= '0;
            pos_y <= '0;
        end else if (pos_we) begin
            pos_x <= pos_x_in;
            pos_y <= pos_y_in;
        end
    end

    cursor_hit_calc #(.POS_W(POS_W), .DIM(DIM)) u_hit (
        .pix_x(pix_x), .pix_y(pix_y), .pos_x(pos_x), .pos_y(pos_y),
        .interlace(interlace), .hit(hit), .byte_off(byte_off), .bit_col(bit_col)
    );

    cursor_img_ram #(.AW(IMG_AW)) u_ram (
        .clk(clk), .rst_n(rst_n), .ld(img_ld), .ld_addr(img_ld_addr),
        .we(img_we), .wdata(img_wdata), .rd_addr(byte_off),
        .p0_byte(p0_byte), .p1_byte(p1_byte)
    );

    cursor_color_regs u_col (
        .clk(clk), .rst_n(rst_n), .ld(col_ld), .ld_addr(col_ld_addr),
        .we(col_we), .wdata(col_wdata), .ovs(ovs_c), .bg(bg_c), .fg(fg_c)
    );

    // Pixel decode: leftmost pixel is the byte's top bit.
    always_comb begin
        p0_bit = p0_byte[3'd7 - bit_col];
        p1_bit = p1_byte[3'd7 - bit_col];
        merged = pix_in;
        if (mode != 2'd0 && hit && p1_bit)
            merged = p0_bit ? fg_c : bg_c;
        ovs_rgb = ovs_c;
    end

    // Output register giving the fixed one-cycle latency.
    always_ff @(posedge clk) begin
        if (!rst_n) pix_out <= '0;
        else        pix_out <= merged;
    end

    // R7: a disabled cursor passes the pixel through.
    a_r7_mode_off: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd0) |=> (pix_out == $past(pix_in)));
    // R4: pixels outside the window pass through.
    a_r4_outside: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit) |=> (pix_out == $past(pix_in)));
    // R5: a clear plane 1 bit is transparent.
    a_r5_transparent: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !p1_bit) |=> (pix_out == $past(pix_in)));
    // R5: an opaque foreground pixel shows the foreground entry.
    a_r5_foreground: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != 2'd0 && hit && p1_bit && p0_bit) |=> (pix_out == $past(fg_c)));
endmodule

// File: tb/cursor_overlay_bench.sv
module cursor_overlay_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        img_ld = 0, img_we = 0, col_ld = 0, col_we = 0, pos_we = 0;
    logic [9:0]  img_ld_addr = '0;
    logic [7:0]  img_wdata = '0, col_wdata = '0;
    logic [1:0]  col_ld_addr = '0, mode = '0;
    logic [11:0] pos_x_in = '0, pos_y_in = '0, pix_x = '0, pix_y = '0;
    logic        interlace = 0;
    logic [23:0] pix_in = '0;
    logic [23:0] pix_out, ovs_rgb;

    int n_vec = 0, n_bad = 0;
    logic [7:0] model [1024];
    int cfg_px, cfg_py, cfg_mode, cfg_il;
    logic [23:0] bg_v, fg_v;

    always #4 clk = ~clk;

    cursor_overlay u_cursor_overlay (
        .clk(clk), .rst_n(rst_n), .img_ld(img_ld), .img_ld_addr(img_ld_addr),
        .img_we(img_we), .img_wdata(img_wdata), .col_ld(col_ld),
        .col_ld_addr(col_ld_addr), .col_we(col_we), .col_wdata(col_wdata),
        .pos_we(pos_we), .pos_x_in(pos_x_in), .pos_y_in(pos_y_in), .mode(mode),
        .interlace(interlace), .pix_x(pix_x), .pix_y(pix_y), .pix_in(pix_in),
        .pix_out(pix_out), .ovs_rgb(ovs_rgb)
    );

    task automatic check(input string req, input logic [23:0] got, input logic [23:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s actual %h expected %h", req, got, exp);
        end
    endtask

    function automatic logic [23:0] pix_pat(int x, int y);
        return {8'(x ^ 8'h5A), 8'(y), 8'(x + y)};
    endfunction

    // Expected output from R3, R4, R5, R7, R8.
    function automatic logic [23:0] expect_px(int x, int y);
        int ey, dx, dy, a, b;
        logic p0, p1;
        ey = cfg_il != 0 ? (cfg_py & ~1) : cfg_py;
        dx = x + 64 - cfg_px;
        dy = y + 64 - ey;
        if (cfg_mode == 0 || dx < 0 || dx > 63 || dy < 0 || dy > 63) return pix_pat(x, y);
        a = dy * 8 + dx / 8;
        b = 7 - (dx % 8);
        p0 = model[a][b];
        p1 = model[a + 512][b];
        if (!p1) return pix_pat(x, y);
        return p0 ? fg_v : bg_v;
    endfunction

    task automatic img_write(input logic [7:0] d);
        @(negedge clk); img_we = 1; img_wdata = d;
        @(negedge clk); img_we = 0;
    endtask

    task automatic col_write(input logic [7:0] d);
        @(negedge clk); col_we = 1; col_wdata = d;
        @(negedge clk); col_we = 0;
    endtask

    task automatic col_load(input logic [1:0] a);
        @(negedge clk); col_ld = 1; col_ld_addr = a;
        @(negedge clk); col_ld = 0;
    endtask

    task automatic set_cfg(input int px, input int py, input int md, input int il);
        cfg_px = px; cfg_py = py; cfg_mode = md; cfg_il = il;
        @(negedge clk);
        pos_we = 1; pos_x_in = 12'(px); pos_y_in = 12'(py);
        mode = 2'(md); interlace = il[0];
        @(negedge clk); pos_we = 0;
    endtask

    // R9: each output is checked one clock after its input.
    task automatic sweep(input string req);
        logic [23:0] prev;
        bit first = 1;
        for (int y = 0; y < 80; y++) begin
            for (int x = 0; x < 80; x++) begin
                @(negedge clk);
                if (!first) check(req, pix_out, prev);
                pix_x = 12'(x); pix_y = 12'(y); pix_in = pix_pat(x, y);
                prev = expect_px(x, y);
                first = 0;
            end
        end
        @(negedge clk);
        check(req, pix_out, prev);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        pix_in = 24'hFFFFFF;
        repeat (3) @(negedge clk);
        check("R1 pix_out reset", pix_out, 24'h0);
        check("R1 colour reset", ovs_rgb, 24'h0);
        rst_n = 1;

        // R2: full load from 0, then two more bytes wrapping to 0 and 1.
        @(negedge clk); img_ld = 1; img_ld_addr = 10'd0;
        @(negedge clk); img_ld = 0;
        for (int i = 0; i < 1024; i++) begin
            model[i] = 8'((i * 73 + 29) ^ (i >> 2));
            img_write(model[i]);
        end
        model[0] = 8'hFF; img_write(8'hFF);
        model[1] = 8'h0F; img_write(8'h0F);
        model[512] = 8'hF0; model[513] = 8'hFF;
        @(negedge clk); img_ld = 1; img_ld_addr = 10'd512;
        @(negedge clk); img_ld = 0;
        img_write(8'hF0); img_write(8'hFF);

        // R6/R10: overscan, background, foreground in one run from address 0.
        col_load(2'd0);
        col_write(8'h0F); col_write(8'h0E); col_write(8'h0D);
        col_write(8'h11); col_write(8'h22); col_write(8'h33);
        col_write(8'hA0); col_write(8'hB0); col_write(8'hC0);
        bg_v = 24'h112233; fg_v = 24'hA0B0C0;
        @(negedge clk);
        check("R6 overscan entry", ovs_rgb, 24'h0F0E0D);
        // R6: address 3 discards writes, then wraps to overscan.
        col_load(2'd3);
        col_write(8'h99); col_write(8'h98); col_write(8'h97);
        @(negedge clk);
        check("R6 entry 3 discarded", ovs_rgb, 24'h0F0E0D);
        col_write(8'h44); col_write(8'h55); col_write(8'h66);
        @(negedge clk);
        check("R6 wrap 3 to 0", ovs_rgb, 24'h445566);

        set_cfg(64 + 5, 64 + 7, 3, 0);   sweep("R3/R4/R5 inside window");
        set_cfg(64 - 10, 64 - 20, 3, 0); sweep("R4 partly off left/top edge");
        set_cfg(64 + 3, 64 + 9, 3, 1);   sweep("R8 interlace odd pos_y");
        set_cfg(64 + 3, 64 + 9, 1, 0);   sweep("R7 nonzero mode, odd pos_y");
        set_cfg(64 + 5, 64 + 7, 0, 0);   sweep("R7 mode 0 passthrough");

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule